// File: doc/BRIEF.md
# Dual Window Watchdog Supervisor

This block watches two independent square-wave heartbeat inputs, each coming from its own controller, using a slow timing tick (nominally 1 kHz) that is supplied as a one-cycle enable on a fast clock. A six-stage shift register filters each heartbeat. A level change is accepted only when three old-level samples are followed by three new-level samples. Every accepted change, from either input, goes to one shared window counter. The counter flags edges that come too close together and raises a dominant self-reset pulse when they come too far apart.

From that supervision the block derives an enable output and the drive commands for a valve relay, a motor relay, a warning lamp and an inverted lamp relay. In normal operation the motor relay follows a motor command input and the lamp pair follows a lamp command input. Any supervision fault forces a safe pattern instead. A long silence on the heartbeats latches an error flag that only the power-on reset can clear. Voltage supervision sits outside the block. It reaches the block as an undervoltage reset input, which clears the qualification state, and as a fault input, which forces the safe pattern.

Top module: `dual_wdog_supervisor`

## Requirements
- R1: Each input is sampled at every tick. A change is accepted at the tick after the third consecutive sample of the new level, and only if the three samples before those held the old level. A pulse of one or two samples produces no accepted edge.
- R2: If two accepted edges (from either input) come fewer than 3 ticks apart, that is a window violation.
- R3: A shared counter counts ticks since the last accepted edge. At the 16th tick with no accepted edge it raises a counter-reset pulse, which is a violation and restarts the count, so the pulse repeats every 16 ticks. An edge accepted in the same tick as this pulse is discarded. A spacing of exactly 15 ticks is legal.
- R4: The safe pattern is: en_o low, valve_on low, motor_on low, lamp_inv_on low and lamp_on high. A violation drops the qualification of both inputs, so the block shows the safe pattern until it is qualified again.
- R5: en_o goes high once each input has delivered a non-violating accepted falling edge since reset or since the last violation. An input that starts high needs one real edge; an input that starts low needs two.
- R6: While enabled, valve_on is high, motor_on equals mr_cmd, lamp_inv_on equals lamp_cmd and lamp_on is the inverse of lamp_cmd.
- R7: err_flag sets at the 121st consecutive tick without an accepted edge. Once set, it stays set until rst_n is asserted.
- R8: While err_flag is set, the outputs show the safe pattern whatever the heartbeat inputs do.
- R9: A low level on uv_rst_n clears the input filters, the window counter, the silence counter and the qualification state at the next clock edge. It does not clear err_flag.
- R10: sup_fault high forces the safe pattern combinationally. It does not clear the qualification state, so the outputs return at once when sup_fault falls.
- R11: An input held at a constant level, such as an open input that reads high, never qualifies, and en_o stays low.
- R12: After rst_n the outputs show the safe pattern and err_flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low; the only clear for err_flag |
| tick | input | 1 | One-cycle timing enable, the supervision time base |
| uv_rst_n | input | 1 | Synchronous undervoltage reset, active low |
| sup_fault | input | 1 | External supervision fault; forces the safe pattern |
| wd_in | input | N_CH | Heartbeat inputs, one bit per supervised controller |
| mr_cmd | input | 1 | Motor relay request |
| lamp_cmd | input | 1 | Lamp request; high turns the lamp off and the lamp relay on |
| en_o | output | 1 | System enable, high when supervision is satisfied |
| valve_on | output | 1 | Valve relay drive |
| motor_on | output | 1 | Motor relay drive |
| lamp_on | output | 1 | Warning lamp drive, on in the safe state |
| lamp_inv_on | output | 1 | Inverted lamp relay drive |
| err_flag | output | 1 | Sticky long-silence error |

## Verification
The bench targets several corner cases, and each has a distinct failure signature.

- Two-tick glitches inside a half period. A filter that accepts a short pulse raises a false short-spacing violation and drops enable.
- Heartbeats with a half period of exactly 15 ticks and of exactly 16 ticks. A window counter that is off by one either drops enable at 15 or never lets the dominant pulse discard the edges at 16. In the second case err_flag would also never latch.
- A one-tick skew between the two inputs. A design that keeps a separate window per input misses this violation.
- A constant-high input, and an undervoltage pulse while err_flag is set. The first catches an edge detector that takes the power-up level for a heartbeat. The second catches a design whose undervoltage reset wipes the sticky error.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
   // accepted-edge pulses of one heartbeat input, valid for one tick
   typedef struct packed {
      logic rise;
      logic fall;
   } wdg_edge_t;
endpackage

// File: rtl/wdg_edge_qual.sv
`timescale 1ns/1ps
module wdg_edge_qual
   import wdg_pkg::*;
#(
   parameter int unsigned SR_LEN = 6
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  logic      tick,
   input  logic      wd_in,
   output wdg_edge_t ev
);
   localparam int unsigned HALF = SR_LEN / 2;
   // newest sample sits in bit 0: old level in the upper half, new level in the lower half
   localparam logic [SR_LEN-1:0] RISE_PAT = {{HALF{1'b0}}, {HALF{1'b1}}};
   localparam logic [SR_LEN-1:0] FALL_PAT = ~RISE_PAT;

   if (SR_LEN < 4 || (SR_LEN % 2) != 0) begin : g_bad_len
      $error("wdg_edge_qual: SR_LEN must be even and at least 4");
   end

   logic [SR_LEN-1:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hist_q <= '0;
      else if (clr)
         hist_q <= '0;
      else if (tick)
         hist_q <= {hist_q[SR_LEN-2:0], wd_in};
   end

   assign ev.rise = tick & ~clr & (hist_q == RISE_PAT);
   assign ev.fall = tick & ~clr & (hist_q == FALL_PAT);
endmodule

// File: rtl/wdg_window.sv
`timescale 1ns/1ps
module wdg_window #(
   parameter int unsigned WIN_MIN   = 3,
   parameter int unsigned WIN_MAX   = 15,
   parameter int unsigned ERR_LIMIT = 120
)(
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic edge_any,
   output logic viol,
   output logic edge_ok,
   output logic err_flag
);
   localparam int unsigned CNT_W  = $clog2(WIN_MAX + 1);
   localparam int unsigned LONG_W = $clog2(ERR_LIMIT + 1);
   localparam logic [CNT_W-1:0]  CNT_TOP   = CNT_W'(WIN_MAX);
   localparam logic [CNT_W-1:0]  SHORT_LIM = CNT_W'(WIN_MIN - 1);
   localparam logic [LONG_W-1:0] LONG_TOP  = LONG_W'(ERR_LIMIT);

   if (WIN_MIN < 2 || WIN_MIN >= WIN_MAX || ERR_LIMIT <= WIN_MAX) begin : g_bad_win
      $error("wdg_window: need 2 <= WIN_MIN < WIN_MAX < ERR_LIMIT");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [LONG_W-1:0] long_q;
   logic              err_q;
   logic              ovf, edge_take, too_short;

   // the counter-reset pulse dominates an edge arriving in the same tick
   assign ovf       = tick & ~clr & (cnt_q == CNT_TOP);
   assign edge_take = edge_any & ~ovf & ~clr;
   assign too_short = edge_take & (cnt_q < SHORT_LIM);
   assign viol      = ovf | too_short;
   assign edge_ok   = edge_take & ~too_short;
   assign err_flag  = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         long_q <= '0;
      end else if (clr) begin
         cnt_q  <= '0;
         long_q <= '0;
      end else begin
         if (ovf || edge_take)
            cnt_q <= '0;
         else if (tick)
            cnt_q <= cnt_q + CNT_W'(1);

         if (edge_take)
            long_q <= '0;
         else if (tick && long_q != LONG_TOP)
            long_q <= long_q + LONG_W'(1);
      end
   end

   // sticky: only the power-on reset clears it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_q <= 1'b0;
      else if (tick && !clr && !edge_take && long_q == LONG_TOP)
         err_q <= 1'b1;
   end
endmodule

// File: rtl/wdg_gate.sv
`timescale 1ns/1ps
module wdg_gate #(
   parameter int unsigned N_CH = 2
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            viol,
   input  logic            edge_ok,
   input  logic [N_CH-1:0] fall_v,
   input  logic            err_flag,
   input  logic            sup_fault,
   input  logic            mr_cmd,
   input  logic            lamp_cmd,
   output logic            en_o,
   output logic            valve_on,
   output logic            motor_on,
   output logic            lamp_on,
   output logic            lamp_inv_on
);
   logic [N_CH-1:0] arm_v;
   logic            healthy;

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_arm
      logic arm_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            arm_q <= 1'b0;
         else if (clr || viol)
            arm_q <= 1'b0;
         else if (edge_ok && fall_v[ch])
            arm_q <= 1'b1;
      end
      assign arm_v[ch] = arm_q;
   end

   assign healthy     = (&arm_v) & ~err_flag & ~sup_fault;
   assign en_o        = healthy;
   assign valve_on    = healthy;
   assign motor_on    = healthy & mr_cmd;
   assign lamp_inv_on = healthy & lamp_cmd;
   assign lamp_on     = ~(healthy & lamp_cmd);
endmodule

// File: rtl/dual_wdog_supervisor.sv
`timescale 1ns/1ps
module dual_wdog_supervisor
   import wdg_pkg::*;
#(
   parameter int unsigned N_CH      = 2,
   parameter int unsigned SR_LEN    = 6,
   parameter int unsigned WIN_MIN   = 3,
   parameter int unsigned WIN_MAX   = 15,
   parameter int unsigned ERR_LIMIT = 120
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            uv_rst_n,
   input  logic            sup_fault,
   input  logic [N_CH-1:0] wd_in,
   input  logic            mr_cmd,
   input  logic            lamp_cmd,
   output logic            en_o,
   output logic            valve_on,
   output logic            motor_on,
   output logic            lamp_on,
   output logic            lamp_inv_on,
   output logic            err_flag
);
   if (N_CH < 1) begin : g_bad_ch
      $error("dual_wdog_supervisor: N_CH must be at least 1");
   end

   logic            uv_clr;
   logic [N_CH-1:0] rise_v, fall_v;
   logic            edge_any, viol, edge_ok;

   assign uv_clr = ~uv_rst_n;

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      wdg_edge_t ev;
      wdg_edge_qual #(.SR_LEN(SR_LEN)) u_qual (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (uv_clr),
         .tick  (tick),
         .wd_in (wd_in[ch]),
         .ev    (ev)
      );
      assign rise_v[ch] = ev.rise;
      assign fall_v[ch] = ev.fall;
   end

   assign edge_any = |(rise_v | fall_v);

   wdg_window #(
      .WIN_MIN   (WIN_MIN),
      .WIN_MAX   (WIN_MAX),
      .ERR_LIMIT (ERR_LIMIT)
   ) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (uv_clr),
      .tick     (tick),
      .edge_any (edge_any),
      .viol     (viol),
      .edge_ok  (edge_ok),
      .err_flag (err_flag)
   );

   wdg_gate #(.N_CH(N_CH)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (uv_clr),
      .viol        (viol),
      .edge_ok     (edge_ok),
      .fall_v      (fall_v),
      .err_flag    (err_flag),
      .sup_fault   (sup_fault),
      .mr_cmd      (mr_cmd),
      .lamp_cmd    (lamp_cmd),
      .en_o        (en_o),
      .valve_on    (valve_on),
      .motor_on    (motor_on),
      .lamp_on     (lamp_on),
      .lamp_inv_on (lamp_inv_on)
   );
endmodule

// File: rtl/wdg_chk.sv
`timescale 1ns/1ps
module wdg_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic uv_rst_n,
   input logic sup_fault,
   input logic mr_cmd,
   input logic en_o,
   input logic valve_on,
   input logic motor_on,
   input logic lamp_on,
   input logic lamp_inv_on,
   input logic err_flag
);
   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag) else $error("err_flag dropped without power-on reset");

   // R7
   err_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(tick)) else $error("err_flag set outside a tick");

   // R8
   safe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag || sup_fault) |-> (!en_o && !valve_on && !motor_on && !lamp_inv_on && lamp_on))
      else $error("safe pattern missing during fault");

   // R9
   uv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !uv_rst_n |=> !en_o) else $error("enable survived undervoltage reset");

   // R6
   motor_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      motor_on |-> (valve_on && mr_cmd)) else $error("motor on without valve or request");

   // R6
   lamp_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({lamp_on, lamp_inv_on}) == 1) else $error("lamp pair not complementary");

   // R5
   en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_o) |-> ($past(tick) || $fell(sup_fault))) else $error("enable rose without a tick");
endmodule

bind dual_wdog_supervisor wdg_chk u_chk (.*);

// File: tb/tb_dual_wdog_supervisor.sv
`timescale 1ns/1ps
module tb_dual_wdog_supervisor;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       uv_rst_n = 1'b1;
   logic       sup_fault = 1'b0;
   logic [1:0] wd_in = 2'b00;
   logic       mr_cmd = 1'b0;
   logic       lamp_cmd = 1'b0;
   logic       en_o, valve_on, motor_on, lamp_on, lamp_inv_on, err_flag;

   always #2.5 clk = ~clk;

   dual_wdog_supervisor dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .uv_rst_n(uv_rst_n),
      .sup_fault(sup_fault), .wd_in(wd_in), .mr_cmd(mr_cmd), .lamp_cmd(lamp_cmd),
      .en_o(en_o), .valve_on(valve_on), .motor_on(motor_on), .lamp_on(lamp_on),
      .lamp_inv_on(lamp_inv_on), .err_flag(err_flag)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // behavioural reference: run lengths of equal samples per input
   bit m_lvl [2];
   int m_cur [2];
   int m_prv [2];
   bit m_arm [2];
   int m_cnt, m_lng;
   bit m_err;

   // heartbeat generator state
   bit g_lvl [2];
   int g_ph  [2];
   bit noise = 0;
   bit glitch = 0;

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int c = 0; c < 2; c++) begin
         m_lvl[c] = 0; m_cur[c] = 6; m_prv[c] = 0; m_arm[c] = 0;
      end
      m_cnt = 0; m_lng = 0; m_err = 0;
   endtask

   task automatic silence_tick();
      if (m_lng == 120) m_err = 1;
      else m_lng++;
   endtask

   task automatic model_step(input bit tk);
      bit acc_r [2];
      bit acc_f [2];
      bit any_e, bad;
      if (!uv_rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_lvl[c] = 0; m_cur[c] = 6; m_prv[c] = 0; m_arm[c] = 0;
         end
         m_cnt = 0; m_lng = 0;
         return;
      end
      if (!tk) return;
      any_e = 0;
      for (int c = 0; c < 2; c++) begin
         acc_r[c] = (m_lvl[c] == 1) && (m_cur[c] == 3) && (m_prv[c] >= 3);
         acc_f[c] = (m_lvl[c] == 0) && (m_cur[c] == 3) && (m_prv[c] >= 3);
         any_e = any_e | acc_r[c] | acc_f[c];
         if (wd_in[c] == m_lvl[c]) begin
            if (m_cur[c] < 7) m_cur[c]++;
         end else begin
            m_prv[c] = m_cur[c]; m_cur[c] = 1; m_lvl[c] = wd_in[c];
         end
      end
      bad = 0;
      if (m_cnt == 15) begin
         bad = 1; m_cnt = 0; silence_tick();
      end else if (any_e) begin
         m_lng = 0;
         if (m_cnt < 2) bad = 1;
         else for (int c = 0; c < 2; c++) if (acc_f[c]) m_arm[c] = 1;
         m_cnt = 0;
      end else begin
         m_cnt++; silence_tick();
      end
      if (bad) begin m_arm[0] = 0; m_arm[1] = 0; end
   endtask

   task automatic compare();
      bit ok;
      ok = m_arm[0] & m_arm[1] & !m_err & !sup_fault;
      check("R5", "en_o",        en_o,        ok);
      check("R4", "valve_on",    valve_on,    ok);
      check("R6", "motor_on",    motor_on,    ok & mr_cmd);
      check("R6", "lamp_inv_on", lamp_inv_on, ok & lamp_cmd);
      check("R6", "lamp_on",     lamp_on,     !(ok & lamp_cmd));
      check("R7", "err_flag",    err_flag,    m_err);
   endtask

   task automatic cyc(input bit tk);
      tick = tk;
      @(negedge clk);
      model_step(tk);
      compare();
   endtask

   task automatic do_reset();
      rst_n = 0; tick = 0; uv_rst_n = 1; sup_fault = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      model_reset();
      compare();
      // R12: safe pattern straight out of reset, even with both commands high
      check("R12", "en_o",        en_o,        1'b0);
      check("R12", "valve_on",    valve_on,    1'b0);
      check("R12", "motor_on",    motor_on,    1'b0);
      check("R12", "lamp_on",     lamp_on,     1'b1);
      check("R12", "lamp_inv_on", lamp_inv_on, 1'b0);
      check("R12", "err_flag",    err_flag,    1'b0);
   endtask

   task automatic wave(input int n, input int ha, input int hb);
      for (int t = 0; t < n; t++) begin
         logic a;
         a = g_lvl[0];
         if (glitch && !g_lvl[0] && (g_ph[0] == 4 || g_ph[0] == 5)) a = 1'b1;
         wd_in = {g_lvl[1], a};
         if (noise) begin
            sup_fault = (($urandom % 40) == 0);
            uv_rst_n  = (($urandom % 150) != 0);
         end
         cyc(1'b1);
         if (noise) begin sup_fault = 0; uv_rst_n = 1; end
         cyc(1'b0);
         g_ph[0]++;
         if (g_ph[0] >= ha) begin g_ph[0] = 0; g_lvl[0] = !g_lvl[0]; end
         g_ph[1]++;
         if (g_ph[1] >= hb) begin g_ph[1] = 0; g_lvl[1] = !g_lvl[1]; end
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd61711));
      mr_cmd = 1; lamp_cmd = 1;
      g_lvl[0] = 1; g_lvl[1] = 1; g_ph[0] = 0; g_ph[1] = 0;
      wd_in = 2'b11;
      do_reset();

      // R5: inputs start high, one real falling edge each qualifies
      wave(40, 8, 8);
      check("R5", "en after start-up", en_o, 1'b1);
      check("R4", "valve while healthy", valve_on, 1'b1);
      check("R6", "motor follows request", motor_on, 1'b1);
      check("R6", "lamp relay follows request", lamp_inv_on, 1'b1);
      check("R6", "lamp off on request", lamp_on, 1'b0);
      mr_cmd = 0; lamp_cmd = 0;
      wave(4, 8, 8);
      check("R6", "motor released", motor_on, 1'b0);
      check("R6", "lamp on without request", lamp_on, 1'b1);
      check("R6", "lamp relay off", lamp_inv_on, 1'b0);

      // R10: external fault masks outputs, qualification kept
      sup_fault = 1; cyc(1'b0);
      check("R10", "en masked by fault", en_o, 1'b0);
      check("R10", "lamp on in fault", lamp_on, 1'b1);
      sup_fault = 0; cyc(1'b0);
      check("R10", "en back after fault", en_o, 1'b1);

      // R1: two-tick glitches inside the low half are filtered
      glitch = 1;
      wave(60, 10, 10);
      glitch = 0;
      check("R1", "en kept through glitches", en_o, 1'b1);

      // R2: one-tick skew between inputs gives too-close edges
      g_lvl[1] = g_lvl[0]; g_ph[1] = (g_ph[0] + 1) % 8;
      wave(40, 8, 8);
      check("R2", "en dropped on close edges", en_o, 1'b0);
      check("R4", "valve off on violation", valve_on, 1'b0);
      check("R4", "lamp on on violation", lamp_on, 1'b1);
      g_lvl[1] = g_lvl[0]; g_ph[1] = g_ph[0];
      wave(40, 8, 8);
      check("R5", "requalified after violation", en_o, 1'b1);

      // R3: spacing of 15 is legal, 16 is swallowed by the counter reset
      wave(80, 15, 15);
      check("R3", "spacing 15 stays enabled", en_o, 1'b1);
      wave(60, 16, 16);
      check("R3", "spacing 16 drops enable", en_o, 1'b0);
      check("R7", "no error yet", err_flag, 1'b0);
      wave(100, 16, 16);
      check("R7", "error after long silence", err_flag, 1'b1);

      // R8: good heartbeats cannot lift the error
      wave(40, 8, 8);
      check("R8", "en held low by error", en_o, 1'b0);
      check("R8", "lamp on with error", lamp_on, 1'b1);

      // R9: undervoltage reset keeps the sticky error
      uv_rst_n = 0; cyc(1'b0); uv_rst_n = 1; cyc(1'b0);
      check("R9", "error kept over undervoltage", err_flag, 1'b1);
      do_reset();
      check("R7", "error cleared by power-on reset", err_flag, 1'b0);

      // R11: a constant-high input never qualifies
      wave(60, 100000, 100000);
      check("R11", "constant input keeps en low", en_o, 1'b0);
      wave(40, 8, 8);
      check("R5", "qualified after constant period", en_o, 1'b1);

      // R9: undervoltage pulse drops enable at the next edge, then requalify
      uv_rst_n = 0; cyc(1'b0); uv_rst_n = 1;
      check("R9", "en cleared by undervoltage", en_o, 1'b0);
      wave(40, 8, 8);
      check("R9", "requalified after undervoltage", en_o, 1'b1);

      // random segments against the reference
      for (int s = 0; s < 60; s++) begin
         int ha, hb;
         if (err_flag) do_reset();
         ha = 3 + int'($urandom % 16);
         hb = (($urandom % 3) == 0) ? 3 + int'($urandom % 16) : ha;
         if (($urandom % 2) == 0) begin g_lvl[1] = g_lvl[0]; g_ph[1] = g_ph[0]; end
         mr_cmd   = ($urandom % 2) == 1;
         lamp_cmd = ($urandom % 2) == 1;
         noise    = ($urandom % 2) == 1;
         glitch   = (($urandom % 4) == 0) && ha >= 8;
         wave(20 + int'($urandom % 60), ha, hb);
         noise = 0; glitch = 0;
      end

      summary();
      $finish;
   end
endmodule